// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block gathers a set of interrupt request lines. It keeps a pending flag, an enable bit and a priority bit for every line. From these it decides when to divert the processor core to one of two fixed entry addresses. In priority mode, the lines marked high priority are gated by a high-level global enable, and the remaining lines are gated by a low-level global enable. A high-priority entry may interrupt a low-priority handler that is already running. A low-priority entry waits for as long as a high-priority handler is in service. In compatibility mode there is only one level and one entry address. The lowest-numbered "core" lines are gated only by the global enable. The other "peripheral" lines also need a peripheral enable.

On each response the controller does four things: it pulses an acknowledge with the entry address, asks the core to push its return address, clears the global enable of the level it took, and marks that level in service. At the same moment it copies the core's status, working and bank-select bytes into a single shadow set. A return request pops the stack and re-arms the level being left. A fast return in priority mode also hands the shadow set back to the core. Software reaches the flag, enable, priority and control words through a small register port.

Top module: `irq_prio_ctrl`

## Requirements
- R1: A pulse on `irq_set[i]` sets flag i. A write to address 0 loads all flags, but a line pulsed in the same cycle stays set. Flags are never cleared by the controller.
- R2: A line can be taken only while both its flag and its enable bit (address 1) are 1. With no such line, `irq_ack` stays 0.
- R3: Priority mode is control bit 0 = 1. A line with priority bit 1 (address 2) is high: it is gated by control bit 1 and enters at `VEC_HI` (0x08). A line with priority bit 0 is low: it is gated by control bit 2 and enters at `VEC_LO` (0x18). If both levels qualify, high wins.
- R4: Line 0 is always high priority. Its priority bit reads back as 1 whatever was written.
- R5: An entry pulses `irq_ack` and `push_req` together for one cycle. It clears the global enable of the level taken (control bit 1 for high, bit 2 for low) and sets that level's in-service bit (bit 3 high, bit 4 low).
- R6: A high entry is taken while a low handler is in service. No low entry is taken while the high in-service bit is set, even with bit 2 rewritten to 1.
- R7: `ret_req` pulses `pop_req` the next cycle. If the high in-service bit is set, it clears that bit and sets bit 1. Otherwise, if the low in-service bit is set, it clears that bit and sets bit 2. If neither is set, only the pop occurs.
- R8: Compatibility mode is control bit 0 = 0. Bit 1 is the global enable and bit 2 the peripheral enable. Lines below `NCORE` need only bit 1; the other lines also need bit 2. Every entry goes to `VEC_HI` and uses the high in-service bit.
- R9: Each entry copies `st_in`, `w_in` and `bsr_in` into the one shadow set shown on `st_out`, `w_out` and `bsr_out`, so a later high entry overwrites a low entry's copy. A return with `ret_fast` = 1 in priority mode pulses `restore_en`; in compatibility mode it does not.
- R10: An entry is never taken in the cycle a return is handled. A request still pending when its level is re-armed is taken in the following cycle.
- R11: After reset, all flags, enables, priority bits and control bits are 0 (line 0 priority still reads 1), and every pulse output is 0.
- R12: Reading shows flags (0), enables (1), priorities (2) or control (3, bits 4..0 = low in-service, high in-service, bit 2, bit 1, mode) on `reg_rdata` one cycle after `reg_addr`. A control write changes only bits 2..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_set | input | NSRC | One-cycle request pulses, one per line |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | NSRC | Write data |
| reg_rdata | output | NSRC | Registered read data |
| ret_req | input | 1 | Return-from-interrupt request |
| ret_fast | input | 1 | Qualifies `ret_req` as a fast return |
| st_in | input | DW | Core status byte |
| w_in | input | DW | Core working register |
| bsr_in | input | DW | Core bank select |
| irq_ack | output | 1 | Entry pulse |
| irq_vec | output | VW | Entry address |
| push_req | output | 1 | Push return address |
| pop_req | output | 1 | Pop return address |
| restore_en | output | 1 | Shadow values valid for restore |
| st_out | output | DW | Shadow status |
| w_out | output | DW | Shadow working register |
| bsr_out | output | DW | Shadow bank select |

## Verification
The bench builds the controller with NSRC = 12 and NCORE = 3. With only 12 lines, sparse random flag and enable patterns frequently leave nothing eligible, or leave only peripheral lines eligible while the peripheral enable is off. The small core group also makes sure that both sides of the compatibility split, as well as the forced-high line 0, show up in many trials. Directed sequences cover nesting, the shadow overwrite, return ordering and re-entry right after a return.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam logic [1:0] A_FLAG = 2'd0;
  localparam logic [1:0] A_EN   = 2'd1;
  localparam logic [1:0] A_PRIO = 2'd2;
  localparam logic [1:0] A_CTRL = 2'd3;
  localparam int C_MODE = 0;
  localparam int C_GHI  = 1;
  localparam int C_GLO  = 2;
  localparam int C_SHI  = 3;
  localparam int C_SLO  = 4;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs #(
  parameter int NSRC = 18
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_set,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] flag,
  output logic [NSRC-1:0] en,
  output logic [NSRC-1:0] prio
);
  import irq_pkg::*;
  logic [NSRC-1:0] prio_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag   <= '0;
      en     <= '0;
      prio_q <= '0;
    end else begin
      if (reg_we && reg_addr == A_FLAG) flag <= reg_wdata | irq_set;
      else                              flag <= flag | irq_set;
      if (reg_we && reg_addr == A_EN)   en     <= reg_wdata;
      if (reg_we && reg_addr == A_PRIO) prio_q <= reg_wdata;
    end
  end

  // line 0 carries no priority storage of its own: always high
  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_prio
      if (i == 0) begin : g_fixed
        assign prio[i] = 1'b1;
      end else begin : g_free
        assign prio[i] = prio_q[i];
      end
    end
  endgenerate
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int NSRC  = 18,
  parameter int NCORE = 5
) (
  input  logic [NSRC-1:0] flag,
  input  logic [NSRC-1:0] en,
  input  logic [NSRC-1:0] prio,
  input  logic            mode_prio,
  input  logic            g_hi,
  input  logic            g_lo,
  input  logic            svc_hi,
  output logic            take_hi,
  output logic            take_lo
);
  logic [NSRC-1:0] pend, core_m;
  logic hi_req, lo_req, core_req, per_req, cmp_take;

  generate
    for (genvar i = 0; i < NSRC; i++) begin : g_core
      assign core_m[i] = (i < NCORE);
    end
  endgenerate

  always_comb begin
    pend     = flag & en;
    hi_req   = |(pend & prio);
    lo_req   = |(pend & ~prio);
    core_req = |(pend & core_m);
    per_req  = |(pend & ~core_m);
    cmp_take = g_hi & (core_req | (g_lo & per_req));
    take_hi  = mode_prio ? (g_hi & hi_req) : cmp_take;
    take_lo  = mode_prio & ~take_hi & g_lo & lo_req & ~svc_hi;
  end
endmodule

// File: rtl/irq_shadow.sv
module irq_shadow #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic [DW-1:0] st_in,
  input  logic [DW-1:0] w_in,
  input  logic [DW-1:0] bsr_in,
  output logic [DW-1:0] st_out,
  output logic [DW-1:0] w_out,
  output logic [DW-1:0] bsr_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_out  <= '0;
      w_out   <= '0;
      bsr_out <= '0;
    end else if (capture) begin
      st_out  <= st_in;
      w_out   <= w_in;
      bsr_out <= bsr_in;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC  = 18,
  parameter int NCORE = 5,
  parameter int DW    = 8,
  parameter int VW    = 21,
  parameter logic [VW-1:0] VEC_HI = 21'h000008,
  parameter logic [VW-1:0] VEC_LO = 21'h000018
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] irq_set,
  input  logic            reg_we,
  input  logic [1:0]      reg_addr,
  input  logic [NSRC-1:0] reg_wdata,
  output logic [NSRC-1:0] reg_rdata,
  input  logic            ret_req,
  input  logic            ret_fast,
  input  logic [DW-1:0]   st_in,
  input  logic [DW-1:0]   w_in,
  input  logic [DW-1:0]   bsr_in,
  output logic            irq_ack,
  output logic [VW-1:0]   irq_vec,
  output logic            push_req,
  output logic            pop_req,
  output logic            restore_en,
  output logic [DW-1:0]   st_out,
  output logic [DW-1:0]   w_out,
  output logic [DW-1:0]   bsr_out
);
  import irq_pkg::*;

  logic [NSRC-1:0] flag, en, prio;
  logic mode_prio, g_hi, g_lo, insvc_hi, insvc_lo;
  logic take_hi, take_lo, take;

  irq_src_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst(rst), .irq_set(irq_set), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .flag(flag), .en(en), .prio(prio)
  );

  irq_select #(.NSRC(NSRC), .NCORE(NCORE)) u_sel (
    .flag(flag), .en(en), .prio(prio), .mode_prio(mode_prio),
    .g_hi(g_hi), .g_lo(g_lo), .svc_hi(insvc_hi),
    .take_hi(take_hi), .take_lo(take_lo)
  );

  // a return in the same cycle defers any entry by one cycle
  assign take = ~ret_req & (take_hi | take_lo);

  irq_shadow #(.DW(DW)) u_shadow (
    .clk(clk), .rst(rst), .capture(take),
    .st_in(st_in), .w_in(w_in), .bsr_in(bsr_in),
    .st_out(st_out), .w_out(w_out), .bsr_out(bsr_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_prio  <= 1'b0;
      g_hi       <= 1'b0;
      g_lo       <= 1'b0;
      insvc_hi   <= 1'b0;
      insvc_lo   <= 1'b0;
      irq_ack    <= 1'b0;
      irq_vec    <= '0;
      push_req   <= 1'b0;
      pop_req    <= 1'b0;
      restore_en <= 1'b0;
    end else begin
      irq_ack    <= 1'b0;
      push_req   <= 1'b0;
      pop_req    <= 1'b0;
      restore_en <= 1'b0;
      if (reg_we && reg_addr == A_CTRL) begin
        mode_prio <= reg_wdata[C_MODE];
        g_hi      <= reg_wdata[C_GHI];
        g_lo      <= reg_wdata[C_GLO];
      end
      // hardware updates below take precedence over a software write
      if (ret_req) begin
        pop_req    <= 1'b1;
        restore_en <= ret_fast & mode_prio;
        if (insvc_hi) begin
          insvc_hi <= 1'b0;
          g_hi     <= 1'b1;
        end else if (insvc_lo) begin
          insvc_lo <= 1'b0;
          g_lo     <= 1'b1;
        end
      end else if (take) begin
        irq_ack  <= 1'b1;
        push_req <= 1'b1;
        if (take_hi) begin
          irq_vec  <= VEC_HI;
          g_hi     <= 1'b0;
          insvc_hi <= 1'b1;
        end else begin
          irq_vec  <= VEC_LO;
          g_lo     <= 1'b0;
          insvc_lo <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      reg_rdata <= '0;
      case (reg_addr)
        A_FLAG: reg_rdata <= flag;
        A_EN:   reg_rdata <= en;
        A_PRIO: reg_rdata <= prio;
        default: begin
          reg_rdata[C_MODE] <= mode_prio;
          reg_rdata[C_GHI]  <= g_hi;
          reg_rdata[C_GLO]  <= g_lo;
          reg_rdata[C_SHI]  <= insvc_hi;
          reg_rdata[C_SLO]  <= insvc_lo;
        end
      endcase
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int VW = 21,
  parameter logic [VW-1:0] VEC_HI = 21'h000008,
  parameter logic [VW-1:0] VEC_LO = 21'h000018
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_ack,
  input logic [VW-1:0] irq_vec,
  input logic          push_req,
  input logic          pop_req,
  input logic          restore_en,
  input logic          ret_req,
  input logic          insvc_hi
);
  AST_VEC_LEGAL: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (irq_vec == VEC_HI || irq_vec == VEC_LO)); // R3
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> push_req); // R5
  AST_LO_ONCE: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec == VEC_LO) |=> !(irq_ack && irq_vec == VEC_LO)); // R5
  AST_LO_HELD: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec == VEC_LO) |-> !$past(insvc_hi)); // R6
  AST_POP_FROM_RET: assert property (@(posedge clk) disable iff (rst)
    pop_req |-> $past(ret_req)); // R7
  AST_RESTORE_POP: assert property (@(posedge clk) disable iff (rst)
    restore_en |-> pop_req); // R9
  AST_RET_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    ret_req |=> !irq_ack); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VW(VW), .VEC_HI(VEC_HI), .VEC_LO(VEC_LO)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_vec(irq_vec),
  .push_req(push_req), .pop_req(pop_req), .restore_en(restore_en),
  .ret_req(ret_req), .insvc_hi(insvc_hi)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int NSRC = 12;
  localparam int NCORE = 3;
  localparam int DW = 8;
  localparam int VW = 21;

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] irq_set = '0, reg_wdata = '0, reg_rdata;
  logic reg_we = 1'b0, ret_req = 1'b0, ret_fast = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [DW-1:0] st_in = '0, w_in = '0, bsr_in = '0, st_out, w_out, bsr_out;
  logic irq_ack, push_req, pop_req, restore_en;
  logic [VW-1:0] irq_vec;

  int nchk = 0, nbad = 0;
  int ack_cnt = 0, push_cnt = 0, pop_cnt = 0, rest_cnt = 0;
  logic [VW-1:0] last_vec = '0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_prio_ctrl #(.NSRC(NSRC), .NCORE(NCORE), .DW(DW), .VW(VW)) dut (
    .clk(clk), .rst(rst), .irq_set(irq_set), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ret_req(ret_req), .ret_fast(ret_fast), .st_in(st_in), .w_in(w_in),
    .bsr_in(bsr_in), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .push_req(push_req), .pop_req(pop_req), .restore_en(restore_en),
    .st_out(st_out), .w_out(w_out), .bsr_out(bsr_out)
  );

  always @(negedge clk) begin
    if (irq_ack) begin ack_cnt++; last_vec = irq_vec; end
    if (push_req) push_cnt++;
    if (pop_req) pop_cnt++;
    if (restore_en) rest_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [NSRC-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [NSRC-1:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic pulse(input logic [NSRC-1:0] s);
    @(negedge clk); irq_set = s;
    @(negedge clk); irq_set = '0;
  endtask

  task automatic ret(input logic f);
    @(negedge clk); ret_req = 1'b1; ret_fast = f;
    @(negedge clk); ret_req = 1'b0; ret_fast = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected entry: bit VW = taken, low bits = address
  function automatic logic [VW:0] exp_entry(input logic [NSRC-1:0] f, e, p,
                                            input logic m, gh, gl);
    logic [NSRC-1:0] pend, pr, core;
    pend = f & e; pr = p | 1; core = (1 << NCORE) - 1;
    if (m) begin
      if (gh && |(pend & pr)) return {1'b1, 21'h8};
      if (gl && |(pend & ~pr)) return {1'b1, 21'h18};
      return '0;
    end
    if (gh && (|(pend & core) || (gl && |(pend & ~core)))) return {1'b1, 21'h8};
    return '0;
  endfunction

  initial begin
    #4_000_000;
    if (!done) begin
      nbad++; nchk++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    logic [NSRC-1:0] d;
    int a0, p0, r0;
    void'($urandom(32'h1c3a5));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R11 reset state
    rd(2'd0, d); chk("R11 flags", d, 0);
    rd(2'd1, d); chk("R11 enables", d, 0);
    rd(2'd2, d); chk("R11 prio (R4 line0)", d, 1);
    rd(2'd3, d); chk("R11 ctrl", d, 0);
    chk("R11 pulses", {irq_ack, push_req, pop_req, restore_en}, 0);

    // R1 set / clear / collision, R12 readback
    pulse(12'h010); rd(2'd0, d); chk("R1 set", d, 12'h010);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = '0; irq_set = 12'h010;
    @(negedge clk); reg_we = 1'b0; irq_set = '0;
    rd(2'd0, d); chk("R1 set wins", d, 12'h010);
    wr(2'd0, 12'h000); rd(2'd0, d); chk("R1 clear", d, 0);
    wr(2'd2, 12'h0a0); rd(2'd2, d); chk("R4 prio forced", d, 12'h0a1);
    wr(2'd3, 12'hff8); rd(2'd3, d); chk("R12 ctrl low bits only", d, 0);

    // R2 flag without enable
    wr(2'd0, 12'hfff); wr(2'd3, 12'h7); a0 = ack_cnt; idle(3);
    chk("R2 no enable", ack_cnt - a0, 0);
    wr(2'd3, 0); wr(2'd0, 0);

    // R3 R5 R6 R9 nesting and clobber
    wr(2'd1, 12'h028); wr(2'd2, 12'h008);
    st_in = 8'h11; w_in = 8'h12; bsr_in = 8'h13;
    pulse(12'h020);
    a0 = ack_cnt; p0 = push_cnt;
    wr(2'd3, 12'h7); idle(3);
    chk("R3 low entry count", ack_cnt - a0, 1);
    chk("R3 low vector", last_vec, 21'h18);
    chk("R5 push with ack", push_cnt - p0, 1);
    rd(2'd3, d); chk("R5 ctrl after low", d, 12'h013);
    chk("R9 shadow low", {st_out, w_out, bsr_out}, 24'h111213);
    st_in = 8'h22; w_in = 8'h23; bsr_in = 8'h24;
    a0 = ack_cnt;
    pulse(12'h008); idle(3);
    chk("R6 high preempts", ack_cnt - a0, 1);
    chk("R3 high vector", last_vec, 21'h8);
    rd(2'd3, d); chk("R5 ctrl nested", d, 12'h019);
    chk("R9 high overwrites", {st_out, w_out, bsr_out}, 24'h222324);
    a0 = ack_cnt;
    wr(2'd3, 12'h5); idle(3);
    chk("R6 low held off", ack_cnt - a0, 0);
    wr(2'd0, 0);
    r0 = rest_cnt; p0 = pop_cnt;
    ret(1'b1); idle(1);
    chk("R9 fast restore", rest_cnt - r0, 1);
    chk("R9 restored values", {st_out, w_out, bsr_out}, 24'h222324);
    chk("R7 pop", pop_cnt - p0, 1);
    rd(2'd3, d); chk("R7 exit high", d, 12'h017);
    r0 = rest_cnt;
    ret(1'b0); rd(2'd3, d); chk("R7 exit low", d, 12'h007);
    chk("R9 plain no restore", rest_cnt - r0, 0);
    p0 = pop_cnt;
    ret(1'b0); rd(2'd3, d); chk("R7 none in service", d, 12'h007);
    chk("R7 pop only", pop_cnt - p0, 1);

    // R10 re-entry after return
    wr(2'd3, 0); pulse(12'h008); a0 = ack_cnt;
    wr(2'd3, 12'h3); idle(3);
    chk("R10 first entry", ack_cnt - a0, 1);
    @(negedge clk); ret_req = 1'b1;
    @(negedge clk); ret_req = 1'b0;
    chk("R10 no ack with pop", {irq_ack, pop_req}, 2'b01);
    a0 = ack_cnt; idle(2);
    chk("R10 re-entry", ack_cnt - a0, 1);
    wr(2'd0, 0); ret(1'b0); wr(2'd3, 0);

    // R8 compatibility mode
    wr(2'd1, 12'hfff); wr(2'd2, 0); pulse(12'h100); a0 = ack_cnt;
    wr(2'd3, 12'h2); idle(3);
    chk("R8 peripheral gated", ack_cnt - a0, 0);
    wr(2'd3, 12'h6); idle(3);
    chk("R8 peripheral enabled", ack_cnt - a0, 1);
    chk("R8 vector", last_vec, 21'h8);
    rd(2'd3, d); chk("R8 ctrl", d, 12'h00c);
    wr(2'd0, 0); r0 = rest_cnt;
    ret(1'b1); idle(1);
    chk("R9 no restore compat", rest_cnt - r0, 0);
    rd(2'd3, d); chk("R8 return", d, 12'h006);
    wr(2'd3, 0); pulse(12'h002); a0 = ack_cnt;
    wr(2'd3, 12'h2); idle(3);
    chk("R8 core line", ack_cnt - a0, 1);
    wr(2'd0, 0); ret(1'b0); wr(2'd3, 0);

    // random trials, R2 R3 R4 R8 R9
    for (int it = 0; it < 300; it++) begin
      logic [NSRC-1:0] f, e, p;
      logic [2:0] c;
      logic [VW:0] x;
      f = NSRC'($urandom & $urandom);
      e = NSRC'($urandom & $urandom);
      p = NSRC'($urandom);
      c = 3'($urandom);
      st_in = 8'($urandom); w_in = 8'($urandom); bsr_in = 8'($urandom);
      wr(2'd3, 0); wr(2'd1, e); wr(2'd2, p); wr(2'd0, f);
      x = exp_entry(f, e, p, c[0], c[1], c[2]);
      a0 = ack_cnt;
      wr(2'd3, NSRC'(c)); idle(3);
      chk("R2 R3 R8 random count", ack_cnt - a0, x[VW] ? 1 : 0);
      if (x[VW]) begin
        chk("R3 R4 R8 random vector", last_vec, x[VW-1:0]);
        chk("R9 random shadow", {st_out, w_out, bsr_out}, {st_in, w_in, bsr_in});
        wr(2'd0, 0); ret(1'b0);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule